// File: doc/BRIEF.md
# MII to RMII Bridge

This block lets a MAC with a 4-bit media-independent port talk to a PHY with a reduced 2-bit port. Everything runs from one reference clock, nominally 50 MHz. On the transmit side, each MAC nibble is split into two dibits. On the receive side, dibits are paired back into nibbles. The single RMII carrier/valid line is split into separate carrier-sense and receive-valid signals. A false carrier from the PHY is turned into the MII error code. The bridge also builds the collision signal, which is held off when full duplex is selected.

The MAC-side transmit and receive clocks are generated here. Each one toggles once per dibit period:
- At 100 Mbps a dibit period is one reference cycle, so the MII clocks run at 25 MHz.
- At 10 Mbps a dibit period is `SLOW_DIV` reference cycles, so the MII clocks run at 2.5 MHz.

The receive clock is realigned on the first preamble dibit, so that each received frame starts on a nibble boundary. The speed and duplex selects are static. They are changed only while reset is held.

Top module: `mii_rmii_bridge`

## Requirements
- R1: `miiTxClk` toggles on every dibit tick. `miiRxClk` also toggles on every dibit tick, except that it goes high on the preamble dibit that starts a frame. Both clocks are low out of reset.
- R2: At 100 Mbps every reference edge is a dibit tick. At 10 Mbps a tick occurs on every `SLOW_DIV`-th edge, and the first tick is on the `SLOW_DIV`-th edge after reset is released. The RMII transmit outputs change only on ticks.
- R3: A MAC nibble and TX enable are sampled on the tick where `miiTxClk` rises. That tick drives TXD[1:0] on `rmiiTxd` and TX enable on `rmiiTxEn`. The next tick drives TXD[3:2].
- R4: `miiTxEr` has no effect on any output.
- R5: In half duplex (`fullDuplex`=0), `miiCol` equals `miiCrs` AND `miiTxEn`.
- R6: With `fullDuplex`=1, `miiCol` stays 0.
- R7: A frame starts when a dibit of 01 arrives with `rmiiCrsDv` high and no frame or false carrier is in progress. That dibit becomes RXD[1:0] and the next dibit becomes RXD[3:2]. On the tick of the second dibit, the nibble is presented with `miiRxDv`=1.
- R8: Inside a frame, `miiRxEr` for a nibble is the OR of `rmiiRxEr` over its two dibits.
- R9: Inside a frame, `miiCrs` falls from the first nibble in which `rmiiCrsDv` is low on either dibit. `miiRxDv` stays high until a nibble has `rmiiCrsDv` low on both dibits. That nibble ends the frame and drives all receive outputs to 0.
- R10: A dibit of 10 with `rmiiCrsDv` high, outside a frame, starts a false carrier. It is shown as RX_ER=1, RX_DV=0, RXD=1110, CRS=1 until a dibit with `rmiiCrsDv` low. A 10 dibit inside a frame is ordinary data.
- R11: While `rmiiCrsDv` is high before any preamble, the bridge reports CRS=1, RX_DV=0, RX_ER=0, RXD=0.
- R12: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock (50 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| speed100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| fullDuplex | input | 1 | 1 suppresses collision |
| miiTxEn | input | 1 | MAC transmit enable |
| miiTxd | input | 4 | MAC transmit nibble |
| miiTxEr | input | 1 | MAC transmit error (ignored) |
| miiTxClk | output | 1 | Generated MII transmit clock |
| miiRxClk | output | 1 | Generated MII receive clock |
| miiRxDv | output | 1 | Receive data valid |
| miiRxd | output | 4 | Received nibble |
| miiRxEr | output | 1 | Receive error / false carrier |
| miiCrs | output | 1 | Carrier sense |
| miiCol | output | 1 | Collision |
| rmiiTxEn | output | 1 | PHY transmit enable |
| rmiiTxd | output | 2 | PHY transmit dibit |
| rmiiCrsDv | input | 1 | PHY combined carrier / data valid |
| rmiiRxd | input | 2 | PHY receive dibit |
| rmiiRxEr | input | 1 | PHY receive error |

## Verification
The bench builds the bridge with `SLOW_DIV`=10. Under that setting it runs every combination of speed and duplex, each after its own reset. This covers the ten-cycle dibit spacing and the one-cycle spacing, and it exercises collision both generated and suppressed while transmit and receive traffic overlap. The receive stimulus covers:
- a carrier before any preamble;
- a preamble that arrives on an odd dibit, which forces receive-clock realignment;
- a 10 dibit inside a frame;
- end-of-frame CRS_DV toggling;
- a false carrier in which 01 dibits must not start a frame.

// File: rtl/mii_rmii_pkg.sv
package mii_rmii_pkg;
  localparam logic [1:0] PREAMBLE_DIBIT = 2'b01;
  localparam logic [1:0] BOGUS_DIBIT    = 2'b10;
  localparam logic [3:0] FALSE_CARRIER_CODE = 4'b1110;

  typedef enum logic [2:0] {
    RX_OUT_IDLE,
    RX_OUT_CARRIER,
    RX_OUT_FALSE,
    RX_OUT_DATA,
    RX_OUT_DATA_NOCRS
  } rxOut_e;

  typedef struct packed {
    logic   txLoad;
    logic   txShift;
    logic   rxLoLoad;
    logic   rxNibDone;
    rxOut_e rxKind;
  } ctrlStrobe_t;
endpackage

// File: rtl/mii_rmii_ctrl.sv
module mii_rmii_ctrl
  import mii_rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        speed100,
  input  logic        crsDv,
  input  logic [1:0]  rxDibit,
  output ctrlStrobe_t strobe,
  output logic        txClk,
  output logic        rxClk
);
  typedef enum logic [1:0] {ST_IDLE, ST_CARRIER, ST_FALSE, ST_FRAME} rxState_e;

  logic slowTick;
  logic tick;

  if (SLOW_DIV > 1) begin : g_div
    localparam int CW = $clog2(SLOW_DIV);
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + CW'(1);
    end
    assign slowTick = (cnt == LAST);
  end else begin : g_nodiv
    assign slowTick = 1'b1;
  end

  assign tick = speed100 | slowTick;

  rxState_e state, stateNx;
  logic txPhase, rxPhase, crsLo, gone, goneNx;
  logic preamble, bogus, startFrame, frameEnd;

  assign preamble   = crsDv && (rxDibit == PREAMBLE_DIBIT);
  assign bogus      = crsDv && (rxDibit == BOGUS_DIBIT);
  assign startFrame = tick && preamble && (state == ST_IDLE || state == ST_CARRIER);
  assign frameEnd   = !crsLo && !crsDv;
  assign goneNx     = gone | !crsLo | !crsDv;

  always_comb begin
    stateNx = state;
    if (tick) begin
      unique case (state)
        ST_IDLE, ST_CARRIER: begin
          if (!crsDv)        stateNx = ST_IDLE;
          else if (preamble) stateNx = ST_FRAME;
          else if (bogus)    stateNx = ST_FALSE;
          else               stateNx = ST_CARRIER;
        end
        ST_FALSE: if (!crsDv) stateNx = ST_IDLE;
        ST_FRAME: if (rxPhase && frameEnd) stateNx = ST_IDLE;
        default:  stateNx = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.txLoad    = tick && !txPhase;
    strobe.txShift   = tick && txPhase;
    strobe.rxLoLoad  = tick && (startFrame || !rxPhase);
    strobe.rxNibDone = tick && rxPhase && !startFrame;
    if (state == ST_FRAME) begin
      if (frameEnd)    strobe.rxKind = RX_OUT_IDLE;
      else if (goneNx) strobe.rxKind = RX_OUT_DATA_NOCRS;
      else             strobe.rxKind = RX_OUT_DATA;
    end else begin
      unique case (stateNx)
        ST_FALSE:   strobe.rxKind = RX_OUT_FALSE;
        ST_CARRIER: strobe.rxKind = RX_OUT_CARRIER;
        default:    strobe.rxKind = RX_OUT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      txPhase <= 1'b0;
      rxPhase <= 1'b0;
      crsLo   <= 1'b0;
      gone    <= 1'b0;
    end else begin
      state <= stateNx;
      if (tick) txPhase <= !txPhase;
      if (startFrame) rxPhase <= 1'b1;
      else if (tick)  rxPhase <= !rxPhase;
      if (strobe.rxLoLoad) crsLo <= crsDv;
      if (strobe.rxNibDone && state == ST_FRAME) gone <= frameEnd ? 1'b0 : goneNx;
    end
  end

  assign txClk = txPhase;
  assign rxClk = rxPhase;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (!speed100 && tick) |=> (!tick || speed100)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxLoLoad, strobe.rxNibDone}) && $onehot0({strobe.txLoad, strobe.txShift})); // R7
  AST_FRAME_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME) |=> (state == ST_FRAME || state == ST_IDLE)); // R10
endmodule

// File: rtl/mii_rmii_datapath.sv
module mii_rmii_datapath
  import mii_rmii_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        miiTxEn,
  input  logic [3:0]  miiTxd,
  input  logic [1:0]  rxDibit,
  input  logic        rxEr,
  output logic        rmiiTxEn,
  output logic [1:0]  rmiiTxd,
  output logic [3:0]  miiRxd,
  output logic        miiRxDv,
  output logic        miiRxEr,
  output logic        miiCrs
);
  logic [1:0] txHi, rxLo;
  logic       erLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rmiiTxd  <= '0;
      rmiiTxEn <= 1'b0;
      txHi     <= '0;
    end else if (strobe.txLoad) begin
      rmiiTxd  <= miiTxd[1:0];
      txHi     <= miiTxd[3:2];
      rmiiTxEn <= miiTxEn;
    end else if (strobe.txShift) begin
      rmiiTxd  <= txHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLo    <= '0;
      erLo    <= 1'b0;
      miiRxd  <= '0;
      miiRxDv <= 1'b0;
      miiRxEr <= 1'b0;
      miiCrs  <= 1'b0;
    end else begin
      if (strobe.rxLoLoad) begin
        rxLo <= rxDibit;
        erLo <= rxEr;
      end
      if (strobe.rxNibDone) begin
        unique case (strobe.rxKind)
          RX_OUT_DATA, RX_OUT_DATA_NOCRS: begin
            miiRxd  <= {rxDibit, rxLo};
            miiRxDv <= 1'b1;
            miiRxEr <= erLo | rxEr;
            miiCrs  <= (strobe.rxKind == RX_OUT_DATA);
          end
          RX_OUT_FALSE: begin
            miiRxd  <= FALSE_CARRIER_CODE;
            miiRxDv <= 1'b0;
            miiRxEr <= 1'b1;
            miiCrs  <= 1'b1;
          end
          RX_OUT_CARRIER: begin
            miiRxd  <= '0;
            miiRxDv <= 1'b0;
            miiRxEr <= 1'b0;
            miiCrs  <= 1'b1;
          end
          default: begin
            miiRxd  <= '0;
            miiRxDv <= 1'b0;
            miiRxEr <= 1'b0;
            miiCrs  <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.txLoad || strobe.txShift) |=> ($stable(rmiiTxd) && $stable(rmiiTxEn))); // R3
  AST_FALSE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (miiRxEr && !miiRxDv) |-> (miiRxd == FALSE_CARRIER_CODE && miiCrs)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!miiCrs && !miiRxDv) |-> (!miiRxEr && miiRxd == 4'd0)); // R9
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge
  import mii_rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       speed100,
  input  logic       fullDuplex,
  input  logic       miiTxEn,
  input  logic [3:0] miiTxd,
  input  logic       miiTxEr,
  output logic       miiTxClk,
  output logic       miiRxClk,
  output logic       miiRxDv,
  output logic [3:0] miiRxd,
  output logic       miiRxEr,
  output logic       miiCrs,
  output logic       miiCol,
  output logic       rmiiTxEn,
  output logic [1:0] rmiiTxd,
  input  logic       rmiiCrsDv,
  input  logic [1:0] rmiiRxd,
  input  logic       rmiiRxEr
);
  ctrlStrobe_t strobe;

  mii_rmii_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(refClk), .rstN(rstN), .speed100(speed100), .crsDv(rmiiCrsDv),
    .rxDibit(rmiiRxd), .strobe(strobe), .txClk(miiTxClk), .rxClk(miiRxClk)
  );

  mii_rmii_datapath u_dp (
    .clk(refClk), .rstN(rstN), .strobe(strobe), .miiTxEn(miiTxEn),
    .miiTxd(miiTxd), .rxDibit(rmiiRxd), .rxEr(rmiiRxEr),
    .rmiiTxEn(rmiiTxEn), .rmiiTxd(rmiiTxd), .miiRxd(miiRxd),
    .miiRxDv(miiRxDv), .miiRxEr(miiRxEr), .miiCrs(miiCrs)
  );

  assign miiCol = !fullDuplex && miiCrs && miiTxEn;

  AST_COL_FULL_DUPLEX: assert property (@(posedge refClk) disable iff (!rstN)
    fullDuplex |-> !miiCol); // R6
  AST_TXER_IGNORED: assert property (@(posedge refClk) disable iff (!rstN)
    (miiTxEr && strobe.txLoad) |=> (rmiiTxd == $past(miiTxd[1:0]) && rmiiTxEn == $past(miiTxEn))); // R4
endmodule

// File: tb/mii_rmii_bridge_bench.sv
module mii_rmii_bridge_bench;
  localparam int DIV = 10;

  logic refClk = 1'b0;
  always #4 refClk = ~refClk;

  logic rstN = 1'b0, speed100 = 1'b1, fullDuplex = 1'b0;
  logic miiTxEn = 1'b0, miiTxEr = 1'b0;
  logic [3:0] miiTxd = '0;
  logic rmiiCrsDv = 1'b0, rmiiRxEr = 1'b0;
  logic [1:0] rmiiRxd = '0;
  logic miiTxClk, miiRxClk, miiRxDv, miiRxEr, miiCrs, miiCol, rmiiTxEn;
  logic [3:0] miiRxd;
  logic [1:0] rmiiTxd;

  mii_rmii_bridge #(.SLOW_DIV(DIV)) u_mii_rmii_bridge (
    .refClk(refClk), .rstN(rstN), .speed100(speed100), .fullDuplex(fullDuplex),
    .miiTxEn(miiTxEn), .miiTxd(miiTxd), .miiTxEr(miiTxEr),
    .miiTxClk(miiTxClk), .miiRxClk(miiRxClk), .miiRxDv(miiRxDv), .miiRxd(miiRxd),
    .miiRxEr(miiRxEr), .miiCrs(miiCrs), .miiCol(miiCol),
    .rmiiTxEn(rmiiTxEn), .rmiiTxd(rmiiTxd),
    .rmiiCrsDv(rmiiCrsDv), .rmiiRxd(rmiiRxd), .rmiiRxEr(rmiiRxEr)
  );

  int checks = 0, errors = 0;
  bit running = 0;
  string rxTag = "R11", txTag = "R3";

  logic [3:0] rxQ[$];    // {er, crsDv, dibit}
  string      rxTagQ[$];
  logic [5:0] txQ[$];    // {er, en, nibble}
  string      txTagQ[$];

  // behavioural reference model
  int mCnt, mTxPh, mHalf, mSt, mGone, mCLo, mErLo;
  int mLo, mTxHi;
  bit mTick;
  int eTxd, eTxEn, eDv, eRxd, eEr, eCrs;

  task automatic modelReset();
    mCnt = 0; mTxPh = 0; mHalf = 0; mSt = 0; mGone = 0; mCLo = 0; mErLo = 0;
    mLo = 0; mTxHi = 0; mTick = 0;
    eTxd = 0; eTxEn = 0; eDv = 0; eRxd = 0; eEr = 0; eCrs = 0;
  endtask

  task automatic rxOut(input int dv, input int rxd, input int er, input int crs);
    eDv = dv; eRxd = rxd; eEr = er; eCrs = crs;
  endtask

  always @(posedge refClk) begin
    if (!rstN) modelReset();
    else begin
      int c, d, er;
      mTick = speed100 || (mCnt == DIV - 1);
      mCnt = (mCnt + 1) % DIV;
      if (mTick) begin
        if (mTxPh == 0) begin
          eTxd = int'(miiTxd[1:0]); mTxHi = int'(miiTxd[3:2]); eTxEn = int'(miiTxEn);
        end else eTxd = mTxHi;
        mTxPh = 1 - mTxPh;
        c = int'(rmiiCrsDv); d = int'(rmiiRxd); er = int'(rmiiRxEr);
        if (mSt == 3) begin
          if (mHalf == 0) begin
            mLo = d; mCLo = c; mErLo = er; mHalf = 1;
          end else begin
            mHalf = 0;
            if (mCLo == 0 && c == 0) begin
              mSt = 0; mGone = 0; rxOut(0, 0, 0, 0);
            end else begin
              if (mCLo == 0 || c == 0) mGone = 1;
              rxOut(1, d * 4 + mLo, (mErLo | er), 1 - mGone);
            end
          end
        end else if (mSt != 2 && c == 1 && d == 1) begin
          mSt = 3; mLo = d; mCLo = c; mErLo = er; mHalf = 1; mGone = 0;
        end else begin
          if (c == 0) mSt = 0;
          else if (mSt != 2 && d == 2) mSt = 2;
          else if (mSt == 0) mSt = 1;
          if (mHalf == 0) mHalf = 1;
          else begin
            mHalf = 0;
            case (mSt)
              2: rxOut(0, 14, 1, 1);
              1: rxOut(0, 0, 0, 1);
              default: rxOut(0, 0, 0, 0);
            endcase
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge refClk) begin
    if (running) begin
      string rT, tT, cT, kT;
      rT = rstN ? rxTag : "R12";
      tT = rstN ? txTag : "R12";
      cT = !rstN ? "R12" : (fullDuplex ? "R6" : "R5");
      kT = rstN ? "R1" : "R12";
      chk(tT, "rmiiTxd", int'(rmiiTxd), eTxd);
      chk(tT, "rmiiTxEn", int'(rmiiTxEn), eTxEn);
      chk(kT, "miiTxClk", int'(miiTxClk), mTxPh);
      chk(kT, "miiRxClk", int'(miiRxClk), mHalf);
      chk(rT, "miiRxDv", int'(miiRxDv), eDv);
      chk(rT, "miiRxd", int'(miiRxd), eRxd);
      chk(rT, "miiRxEr", int'(miiRxEr), eEr);
      chk(rT, "miiCrs", int'(miiCrs), eCrs);
      chk(cT, "miiCol", int'(miiCol), (!fullDuplex && eCrs == 1 && miiTxEn) ? 1 : 0);
      if (rstN && mTick) begin
        if (rxQ.size() > 0) begin
          {rmiiRxEr, rmiiCrsDv, rmiiRxd} = rxQ.pop_front();
          rxTag = rxTagQ.pop_front();
        end else begin
          {rmiiRxEr, rmiiCrsDv, rmiiRxd} = 4'b0000;
        end
        if (mTxPh == 1) begin
          if (txQ.size() > 0) begin
            {miiTxEr, miiTxEn, miiTxd} = txQ.pop_front();
            txTag = txTagQ.pop_front();
          end else begin
            {miiTxEr, miiTxEn, miiTxd} = 6'b0;
            txTag = "R3";
          end
        end
      end
    end
  end

  task automatic pushRx(input logic er, input logic c, input logic [1:0] d, input string tag);
    rxQ.push_back({er, c, d});
    rxTagQ.push_back(tag);
  endtask

  task automatic runConfig(input logic sp, input logic fd);
    @(negedge refClk);
    rstN = 1'b0;
    speed100 = sp; fullDuplex = fd;
    {miiTxEr, miiTxEn, miiTxd} = 6'b0;
    {rmiiRxEr, rmiiCrsDv, rmiiRxd} = 4'b0;
    rxTag = "R12"; txTag = "R12";
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
    // transmit frame, TX_ER toggling (R2, R3, R4)
    for (int i = 0; i < 16; i++) begin
      txQ.push_back({logic'(i[1]), 1'b1, 4'((i * 7 + 3) & 15)});
      txTagQ.push_back(i[1] ? "R4" : "R3");
    end
    txQ.push_back(6'b100000); txTagQ.push_back("R4");
    txQ.push_back(6'b000000); txTagQ.push_back("R2");
    // receive: idle, carrier without preamble, odd-aligned preamble
    for (int i = 0; i < 4; i++) pushRx(1'b0, 1'b0, 2'b00, "R11");
    for (int i = 0; i < 3; i++) pushRx(1'b0, 1'b1, 2'b00, "R11");
    for (int i = 0; i < 6; i++) pushRx(1'b0, 1'b1, 2'b01, "R7");
    pushRx(1'b0, 1'b1, 2'b11, "R7");
    pushRx(1'b0, 1'b1, 2'b01, "R7");
    for (int i = 0; i < 12; i++) pushRx(logic'(i == 5), 1'b1, 2'((i * 3 + 1) & 3), "R8");
    pushRx(1'b0, 1'b1, 2'b10, "R10");
    pushRx(1'b0, 1'b1, 2'b10, "R10");
    for (int i = 0; i < 4; i++) pushRx(1'b0, logic'(i[0]), 2'((i + 2) & 3), "R9");
    for (int i = 0; i < 4; i++) pushRx(1'b0, 1'b0, 2'b00, "R9");
    // false carrier with preamble-looking dibits inside
    pushRx(1'b0, 1'b1, 2'b00, "R10");
    pushRx(1'b0, 1'b1, 2'b10, "R10");
    for (int i = 0; i < 5; i++) pushRx(1'b0, 1'b1, 2'b01, "R10");
    for (int i = 0; i < 4; i++) pushRx(1'b0, 1'b0, 2'b00, "R10");
    while (rxQ.size() > 0 || txQ.size() > 0) @(negedge refClk);
    repeat (6 * DIV) @(negedge refClk);
  endtask

  initial begin
    modelReset();
    running = 1;
    runConfig(1'b1, 1'b0);
    runConfig(1'b1, 1'b1);
    runConfig(1'b0, 1'b0);
    runConfig(1'b0, 1'b1);
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule